// File: doc/BRIEF.md
# Program Counter and Return-Link Writeback Unit

This block owns the program counter of a single-cycle processor that runs a small load/store instruction set: word load and store, register add, subtract, and, or, set-less-than, branch-if-equal, plain jump and jump-with-link. Once per clock it chooses the next fetch address. That address is the sequential address, the branch target or the jump target. Alongside it, the block drives the register-file destination index, the write data and the write strobe for the instruction it is currently executing.

The jump-with-link instruction needs no extra datapath. A single link control from the opcode decoder widens two existing selects. The destination select gains a third choice, the constant register 31. The writeback select gains a third choice, the incremented PC. The register file, ALU and memories sit outside the block. The block receives the instruction word, the ALU zero flag, the sign-extended immediate, the ALU result and the memory read data.

Top module: `npc_link_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first rising clock edge, `pc` reads 0.
- R2: Any instruction that is not a taken branch and not a jump advances `pc` to `pc`+4 at the next rising edge.
- R3: Branch-if-equal (opcode bits 31:26 = 6'b000100) with `alu_zero` high loads `pc`+4+(`imm_ext` shifted left by two). The offset may be negative.
- R4: Branch-if-equal with `alu_zero` low loads `pc`+4 and writes no register.
- R5: Jump (opcode 6'b000010) loads {(`pc`+4)[31:28], `instr`[25:0], 2'b00} and keeps `reg_we` low. The upper four bits come from `pc`+4, not from `pc`.
- R6: Jump-with-link (opcode 6'b000011) loads the same jump target and drives `reg_we`=1, `wr_idx`=31 and `wr_data`=`pc`+4 of the linking instruction.
- R7: For either jump, `alu_zero` and `imm_ext` have no effect on the next `pc`.
- R8: A register instruction (opcode 6'b000000, bits 10:6 zero, bits 5:0 one of 0x20, 0x22, 0x24, 0x25, 0x2A) drives `reg_we`=1, `wr_idx`=`instr`[15:11] and `wr_data`=`alu_result`.
- R9: A word load (opcode 6'b100011) drives `reg_we`=1, `wr_idx`=`instr`[20:16] and `wr_data`=`mem_rdata`.
- R10: A word store (opcode 6'b101011) and a branch keep `reg_we` low.
- R11: A register instruction whose function code is outside that list, or whose bits 10:6 are nonzero, keeps `reg_we` low and advances sequentially. Any unlisted opcode behaves the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 32 | Instruction being executed |
| alu_zero | input | 1 | ALU result-is-zero flag |
| imm_ext | input | 32 | Sign-extended immediate |
| alu_result | input | 32 | ALU output |
| mem_rdata | input | 32 | Data memory read data |
| pc | output | 32 | Current program counter |
| reg_we | output | 1 | Register-file write strobe |
| wr_idx | output | 5 | Register-file destination index |
| wr_data | output | 32 | Register-file write data |

## Verification
The assertions assume that `instr`, `alu_zero` and `imm_ext` are steady and known around every rising edge. They also assume that the sign extension outside the block is already done, so `imm_ext` is trusted as given. The bench changes every input only just after a falling edge, so each value is held across a full rising edge. It chooses branch offsets that steer `pc` deliberately to 0x0FFFFFFC, which makes the jump that follows take its upper bits across a carry into bit 28. That jump is issued with the zero flag high, so any leak from the branch path would show up in `pc`.

// File: rtl/npc_link_pkg.sv
package npc_link_pkg;

  localparam logic [5:0] OP_REG  = 6'b000000;
  localparam logic [5:0] OP_JMP  = 6'b000010;
  localparam logic [5:0] OP_JLNK = 6'b000011;
  localparam logic [5:0] OP_BEQ  = 6'b000100;
  localparam logic [5:0] OP_LDW  = 6'b100011;
  localparam logic [5:0] OP_STW  = 6'b101011;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {
    DST_RT   = 2'd0,
    DST_RD   = 2'd1,
    DST_LINK = 2'd2
  } dst_sel_e;

  typedef enum logic [1:0] {
    WB_ALU = 2'd0,
    WB_MEM = 2'd1,
    WB_PC4 = 2'd2
  } wb_sel_e;

  typedef struct packed {
    logic     reg_we;
    logic     link;
    logic     branch;
    logic     jump;
    dst_sel_e dst_sel;
    wb_sel_e  wb_sel;
  } ctrl_t;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_link_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [4:0] shamt,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  logic reg_ok;
  logic is_reg;
  logic is_ldw;

  always_comb begin
    reg_ok = 1'b0;
    if (shamt == 5'd0) begin
      unique case (funct)
        FN_ADD, FN_SUB, FN_AND, FN_OR, FN_SLT: reg_ok = 1'b1;
        default:                               reg_ok = 1'b0;
      endcase
    end
  end

  always_comb begin
    is_reg      = (opcode == OP_REG) && reg_ok;
    is_ldw      = (opcode == OP_LDW);
    ctrl.link   = (opcode == OP_JLNK);
    ctrl.jump   = (opcode == OP_JMP) || ctrl.link;
    ctrl.branch = (opcode == OP_BEQ);
    ctrl.reg_we = is_reg || is_ldw || ctrl.link;
    // link widens the destination select and the writeback select
    if (ctrl.link)    ctrl.dst_sel = DST_LINK;
    else if (is_reg)  ctrl.dst_sel = DST_RD;
    else              ctrl.dst_sel = DST_RT;
    if (ctrl.link)    ctrl.wb_sel = WB_PC4;
    else if (is_ldw)  ctrl.wb_sel = WB_MEM;
    else              ctrl.wb_sel = WB_ALU;
  end

endmodule

// File: rtl/npc_pc_unit.sv
module npc_pc_unit #(
  parameter int          XLEN     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              branch,
  input  logic              jump,
  input  logic              alu_zero,
  input  logic [XLEN-1:0]   imm_ext,
  input  logic [XLEN-7:0]   jfield,
  output logic [XLEN-1:0]   pc,
  output logic [XLEN-1:0]   pc_plus4
);

  localparam int HI_W = 4;

  logic [XLEN-1:0] br_target;
  logic [XLEN-1:0] jmp_target;
  logic [XLEN-1:0] pc_nxt;
  logic            pc_load;
  logic            br_taken;

  assign pc_load = 1'b1;

  always_comb begin
    pc_plus4   = pc + XLEN'(4);
    br_target  = pc_plus4 + (imm_ext << 2);
    jmp_target = {pc_plus4[XLEN-1 -: HI_W], jfield, 2'b00};
    br_taken   = branch && alu_zero;
    if (jump)          pc_nxt = jmp_target;
    else if (br_taken) pc_nxt = br_target;
    else               pc_nxt = pc_plus4;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc <= RESET_PC[XLEN-1:0];
    else if (pc_load) pc <= pc_nxt;
  end

  // R1: first cycle out of reset still shows the reset address
  p_reset_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pc == RESET_PC[XLEN-1:0]);

  // R2: plain flow steps by one word
  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!jump && !(branch && alu_zero)) |=> pc == $past(pc) + XLEN'(4));

  // R3: taken branch lands at offset from pc+4
  p_branch_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (branch && alu_zero && !jump) |=> pc == $past(pc) + XLEN'(4) + ($past(imm_ext) << 2));

  // R5: jump target is word aligned and keeps the region of pc+4
  p_jump_region_r5: assert property (@(posedge clk) disable iff (!rst_n)
    jump |=> (pc[1:0] == 2'b00) && (pc[XLEN-1 -: HI_W] == $past(pc_plus4[XLEN-1 -: HI_W])));

endmodule

// File: rtl/npc_wb_select.sv
module npc_wb_select
  import npc_link_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int IDX_W    = 5,
  parameter int LINK_REG = 31
) (
  input  dst_sel_e         dst_sel,
  input  wb_sel_e          wb_sel,
  input  logic [IDX_W-1:0] rt,
  input  logic [IDX_W-1:0] rd,
  input  logic [XLEN-1:0]  alu_result,
  input  logic [XLEN-1:0]  mem_rdata,
  input  logic [XLEN-1:0]  pc_plus4,
  output logic [IDX_W-1:0] wr_idx,
  output logic [XLEN-1:0]  wr_data
);

  always_comb begin
    unique case (dst_sel)
      DST_RD:   wr_idx = rd;
      DST_LINK: wr_idx = IDX_W'(LINK_REG);
      default:  wr_idx = rt;
    endcase
    unique case (wb_sel)
      WB_MEM:  wr_data = mem_rdata;
      WB_PC4:  wr_data = pc_plus4;
      default: wr_data = alu_result;
    endcase
  end

endmodule

// File: rtl/npc_link_unit.sv
module npc_link_unit
  import npc_link_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          IDX_W    = 5,
  parameter int          LINK_REG = 31,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [XLEN-1:0]  instr,
  input  logic             alu_zero,
  input  logic [XLEN-1:0]  imm_ext,
  input  logic [XLEN-1:0]  alu_result,
  input  logic [XLEN-1:0]  mem_rdata,
  output logic [XLEN-1:0]  pc,
  output logic             reg_we,
  output logic [IDX_W-1:0] wr_idx,
  output logic [XLEN-1:0]  wr_data
);

  localparam int OP_LSB = XLEN - 6;
  localparam int RT_LSB = OP_LSB - 2*IDX_W;
  localparam int RD_LSB = RT_LSB - IDX_W;
  localparam int SH_LSB = RD_LSB - IDX_W;

  ctrl_t           ctrl;
  logic [XLEN-1:0] pc_plus4;

  npc_decode u_dec (
    .opcode (instr[XLEN-1:OP_LSB]),
    .shamt  (instr[SH_LSB +: 5]),
    .funct  (instr[5:0]),
    .ctrl   (ctrl)
  );

  npc_pc_unit #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .branch   (ctrl.branch),
    .jump     (ctrl.jump),
    .alu_zero (alu_zero),
    .imm_ext  (imm_ext),
    .jfield   (instr[OP_LSB-1:0]),
    .pc       (pc),
    .pc_plus4 (pc_plus4)
  );

  npc_wb_select #(.XLEN(XLEN), .IDX_W(IDX_W), .LINK_REG(LINK_REG)) u_wb (
    .dst_sel    (ctrl.dst_sel),
    .wb_sel     (ctrl.wb_sel),
    .rt         (instr[RT_LSB +: IDX_W]),
    .rd         (instr[RD_LSB +: IDX_W]),
    .alu_result (alu_result),
    .mem_rdata  (mem_rdata),
    .pc_plus4   (pc_plus4),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data)
  );

  assign reg_we = ctrl.reg_we;

  // R6: linking jump writes return address into the link register
  p_link_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[XLEN-1:OP_LSB] == OP_JLNK) |->
      reg_we && (wr_idx == IDX_W'(LINK_REG)) && (wr_data == pc + XLEN'(4)));

  // R5: plain jump never writes
  p_jump_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[XLEN-1:OP_LSB] == OP_JMP) |-> !reg_we);

  // R10: stores and branches never write
  p_store_branch_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((instr[XLEN-1:OP_LSB] == OP_STW) || (instr[XLEN-1:OP_LSB] == OP_BEQ)) |-> !reg_we);

  // R9: load writes memory data to rt
  p_load_path_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[XLEN-1:OP_LSB] == OP_LDW) |->
      reg_we && (wr_data == mem_rdata) && (wr_idx == instr[RT_LSB +: IDX_W]));

endmodule

// File: tb/npc_link_unit_test.sv
module npc_link_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] instr;
  logic        alu_zero;
  logic [31:0] imm_ext;
  logic [31:0] alu_result;
  logic [31:0] mem_rdata;
  logic [31:0] pc;
  logic        reg_we;
  logic [4:0]  wr_idx;
  logic [31:0] wr_data;

  int total = 0;
  int bad   = 0;
  logic [31:0] exp_pc;
  bit done = 1'b0;

  always #4 clk = ~clk;

  npc_link_unit uut (
    .clk(clk), .rst_n(rst_n), .instr(instr), .alu_zero(alu_zero),
    .imm_ext(imm_ext), .alu_result(alu_result), .mem_rdata(mem_rdata),
    .pc(pc), .reg_we(reg_we), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // apply inputs right after a falling edge, check write side, then next pc
  task automatic apply(input logic [31:0] ins, input logic z, input logic [31:0] imm,
                       input logic [31:0] alu, input logic [31:0] mem);
    instr = ins; alu_zero = z; imm_ext = imm; alu_result = alu; mem_rdata = mem;
    #1;
  endtask

  task automatic step_pc(input string req);
    @(negedge clk);
    chk(req, "pc", pc, exp_pc);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    apply(32'h0, 1'b0, 32'h0, 32'h0, 32'h0);
    repeat (2) @(negedge clk);
    chk("R1", "pc in reset", pc, 32'h0);
    rst_n = 1'b1;
    #1;
    chk("R1", "pc after release", pc, 32'h0);
    exp_pc = 32'h0;
  endtask

  task automatic t_reg_add;
    apply({6'h00, 5'd1, 5'd2, 5'd3, 5'd0, 6'h20}, 1'b0, 32'h9, 32'h0000_1234, 32'hAAAA_0000);
    chk("R8", "we", {31'b0, reg_we}, 32'h1);
    chk("R8", "idx", {27'b0, wr_idx}, 32'd3);
    chk("R8", "data", wr_data, 32'h0000_1234);
    exp_pc = exp_pc + 4;
    step_pc("R2");
  endtask

  task automatic t_reg_bad_funct;
    apply({6'h00, 5'd1, 5'd2, 5'd9, 5'd0, 6'h21}, 1'b1, 32'h4, 32'h7, 32'h8);
    chk("R11", "we bad funct", {31'b0, reg_we}, 32'h0);
    apply({6'h00, 5'd1, 5'd2, 5'd9, 5'd3, 6'h20}, 1'b1, 32'h4, 32'h7, 32'h8);
    chk("R11", "we shamt set", {31'b0, reg_we}, 32'h0);
    exp_pc = exp_pc + 4;
    step_pc("R11");
  endtask

  task automatic t_load;
    apply({6'h23, 5'd4, 5'd7, 16'h0010}, 1'b0, 32'h10, 32'h55, 32'hDEAD_BEEF);
    chk("R9", "we", {31'b0, reg_we}, 32'h1);
    chk("R9", "idx", {27'b0, wr_idx}, 32'd7);
    chk("R9", "data", wr_data, 32'hDEAD_BEEF);
    exp_pc = exp_pc + 4;
    step_pc("R2");
  endtask

  task automatic t_store;
    apply({6'h2B, 5'd4, 5'd7, 16'h0020}, 1'b1, 32'h20, 32'h66, 32'h77);
    chk("R10", "we store", {31'b0, reg_we}, 32'h0);
    exp_pc = exp_pc + 4;
    step_pc("R2");
  endtask

  task automatic t_beq_not_taken;
    apply({6'h04, 5'd1, 5'd2, 16'h0005}, 1'b0, 32'h5, 32'h1, 32'h0);
    chk("R10", "we branch", {31'b0, reg_we}, 32'h0);
    exp_pc = exp_pc + 4;
    step_pc("R4");
  endtask

  task automatic t_beq_taken(input logic [31:0] imm);
    apply({6'h04, 5'd1, 5'd2, imm[15:0]}, 1'b1, imm, 32'h0, 32'h0);
    chk("R10", "we taken branch", {31'b0, reg_we}, 32'h0);
    exp_pc = exp_pc + 4 + (imm << 2);
    step_pc("R3");
  endtask

  task automatic t_jal(input logic [25:0] tgt);
    logic [31:0] p4;
    p4 = exp_pc + 4;
    apply({6'h03, tgt}, 1'b1, 32'hFFFF_FF00, 32'h1111_1111, 32'h2222_2222);
    chk("R6", "we", {31'b0, reg_we}, 32'h1);
    chk("R6", "idx", {27'b0, wr_idx}, 32'd31);
    chk("R6", "data", wr_data, p4);
    exp_pc = {p4[31:28], tgt, 2'b00};
    step_pc("R7");
  endtask

  task automatic t_jmp(input logic [25:0] tgt);
    logic [31:0] p4;
    p4 = exp_pc + 4;
    apply({6'h02, tgt}, 1'b1, 32'h0000_0100, 32'h3, 32'h4);
    chk("R5", "we", {31'b0, reg_we}, 32'h0);
    exp_pc = {p4[31:28], tgt, 2'b00};
    step_pc("R5");
  endtask

  initial begin
    t_reset();
    t_reg_add();
    t_load();
    t_store();
    t_beq_not_taken();
    t_reg_bad_funct();
    t_beq_taken(32'hFFFF_FFFE);
    t_beq_taken(32'h0C00_0000);
    t_jmp(26'h123_4567);
    t_reset();
    t_beq_taken(32'h03FF_FFFE);
    t_jal(26'h0AB_CDEF);
    t_jmp(26'h3FF_FFFF);
    t_reg_add();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule